// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Bus Front End

This block sits between a host processor bus and the core of a character display controller. A static strap picks one of two strobe schemes: a bus with one read/write line and one enable strobe, or a bus with a separate write strobe and read strobe. Chip select is active low. A register-select line sends each transfer either to the command side or to the data side. Bytes move either whole on eight data lines or as two nibbles on the upper four lines. A width bit, written through a function-set command, chooses between the two.

All host pins are asynchronous to the fast system clock. The active-strobe condition, the transfer direction, register select and the data lines pass through a two-flop synchronizer together. A transfer is committed when the synchronized strobe falls. Each committed write byte comes out as a single-cycle pulse with a tag that says command or data. Reads return either the status byte (busy flag and address counter from the core) or a prefetched RAM byte held in an output register. Every completed data read hands out the held byte, reloads the register from the RAM data input and pulses a request that tells the core to advance its address. For this reason the first data read after an address change returns the stale byte.

Top module: `hostbus_front`

## Requirements
- R1: With `mode_6800` low, a write is a high pulse on `rw_wr` while `e_rd` stays high. With `mode_6800` high, a write is a high pulse on `e_rd` while `rw_wr` is low. In both cases a write commits after the strobe falls.
- R2: While `cs_n` is high, no strobe activity produces `wr_valid` or `rd_next`.
- R3: `wr_is_data` equals the level of `rs` during the transfer: 0 tags a command byte and 1 tags a data byte.
- R4: A read is a low pulse on `e_rd` when `mode_6800` is low, or a high pulse on `e_rd` with `rw_wr` high when `mode_6800` is high.
- R5: In 4-bit width, a byte is written as two transfers on `db_in[7:4]`, upper half first. `db_in[3:0]` is ignored, and only the second transfer produces `wr_valid`.
- R6: In 4-bit width, a byte is read as two transfers on `db_out[7:4]`, upper half first.
- R7: Reset selects 8-bit width and clears the nibble phase, so the first nibble after reset is the upper half. Reset also clears the output register to 00h.
- R8: A command byte of the form 001x_xxxx sets the width from bit 4: 1 selects 8-bit and 0 selects 4-bit. No other byte changes the width.
- R9: A completed data read returns the output register's current byte, then loads the register from `rd_data`. The first data read after an address set therefore returns the byte fetched before that set.
- R10: A command-side read returns `busy` on bit 7, zeros on bits 6..5 and `ac` on bits 4..0.
- R11: Each completed write byte gives exactly one single-cycle `wr_valid`. Each completed data read byte gives exactly one single-cycle `rd_next`.
- R12: `db_oe` is high only while `cs_n` is low, the direction is read and the read strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_6800 | input | 1 | Strap: 1 = R/W plus enable, 0 = separate strobes |
| cs_n | input | 1 | Chip select, active low |
| rs | input | 1 | Register select: 0 command/status, 1 data |
| rw_wr | input | 1 | R/W line, or write strobe (active high) |
| e_rd | input | 1 | Enable strobe, or read strobe (active low) |
| db_in | input | 8 | Data lines from the host |
| db_out | output | 8 | Data lines toward the host |
| db_oe | output | 1 | Drive enable for `db_out` |
| busy | input | 1 | Busy flag from the core |
| ac | input | 5 | Address counter from the core |
| rd_data | input | 8 | RAM byte at the current address |
| wr_valid | output | 1 | One-cycle pulse per written byte |
| wr_is_data | output | 1 | Tag of the written byte |
| wr_byte | output | 8 | Assembled written byte |
| rd_next | output | 1 | One-cycle pulse per completed data read |

## Verification
The checks assume the host keeps each strobe active, and each idle gap between strobes, for several system clocks. They also assume the host holds register select, direction and data stable while the strobe is active, and changes the mode strap only while deselected and idle. The bench drives every transfer with setup time before the strobe, holds the strobe for four clocks, and leaves at least eight idle clocks before the next one. The deselected-bus check waits six clocks of chip select high before it requires silence, which covers the synchronizer latency of a transfer that finished just as chip select rose.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic {
    NIB_HI = 1'b0,
    NIB_LO = 1'b1
  } nib_ph_e;

  // Command pattern that carries the width bit (top three bits 001).
  function automatic logic is_width_cmd(input logic [7:0] b);
    return b[7:5] == 3'b001;
  endfunction
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hb_strobe.sv
module hb_strobe #(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_6800,
  input  logic          cs_n,
  input  logic          rs,
  input  logic          rw_wr,
  input  logic          e_rd,
  input  logic [DW-1:0] db_in,
  output logic          commit,
  output logic          c_rs,
  output logic          c_rd,
  output logic [DW-1:0] c_d
);
  localparam int SW = DW + 3;

  logic          act_raw, rd_raw;
  logic [SW-1:0] sync_q;
  logic          act_s, rd_s, rs_s;
  logic [DW-1:0] d_s;
  logic          act_q;
  logic          rs_q, rd_q, rs_n, rd_n;
  logic [DW-1:0] d_q, d_n;

  // Strobe qualification is formed from the pins before synchronizing,
  // so the reset value of the synchronizer can never look like a strobe.
  always_comb begin
    if (mode_6800) begin
      act_raw = !cs_n && e_rd;
      rd_raw  = rw_wr;
    end else begin
      act_raw = !cs_n && (rw_wr || !e_rd);
      rd_raw  = !e_rd;
    end
  end

  hb_sync #(.W(SW), .STAGES(STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({act_raw, rd_raw, rs, db_in}),
    .q    (sync_q)
  );

  assign {act_s, rd_s, rs_s, d_s} = sync_q;

  always_comb begin
    rs_n = rs_q;
    rd_n = rd_q;
    d_n  = d_q;
    if (act_s) begin
      rs_n = rs_s;
      rd_n = rd_s;
      d_n  = d_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      rs_q  <= 1'b0;
      rd_q  <= 1'b0;
      d_q   <= '0;
    end else begin
      act_q <= act_s;
      rs_q  <= rs_n;
      rd_q  <= rd_n;
      d_q   <= d_n;
    end
  end

  assign commit = act_q && !act_s;
  assign c_rs   = rs_q;
  assign c_rd   = rd_q;
  assign c_d    = d_q;
endmodule

// File: rtl/hb_width.sv
module hb_width
  import hb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          c_rs,
  input  logic          c_rd,
  input  logic [DW-1:0] c_d,
  output logic          wr_valid,
  output logic          wr_is_data,
  output logic [DW-1:0] wr_byte,
  output logic          rd_next,
  output logic          bus_8bit,
  output nib_ph_e       phase
);
  localparam int NW = DW / 2;

  logic          wv_n, tag_n, rn_n, dl_n;
  logic [DW-1:0] byte_n, full;
  logic [NW-1:0] hi_q, hi_n;
  nib_ph_e       ph_n;
  logic          complete;

  always_comb begin
    wv_n     = 1'b0;
    rn_n     = 1'b0;
    tag_n    = wr_is_data;
    byte_n   = wr_byte;
    dl_n     = bus_8bit;
    hi_n     = hi_q;
    ph_n     = phase;
    complete = bus_8bit || (phase == NIB_LO);
    full     = bus_8bit ? c_d : {hi_q, c_d[DW-1:NW]};
    if (commit) begin
      if (!bus_8bit) begin
        ph_n = (phase == NIB_HI) ? NIB_LO : NIB_HI;
        if (phase == NIB_HI && !c_rd) hi_n = c_d[DW-1:NW];
      end
      if (complete && !c_rd) begin
        wv_n   = 1'b1;
        tag_n  = c_rs;
        byte_n = full;
        if (!c_rs && is_width_cmd(full)) begin
          dl_n = full[4];
          if (full[4]) ph_n = NIB_HI;
        end
      end
      if (complete && c_rd && c_rs) rn_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid   <= 1'b0;
      wr_is_data <= 1'b0;
      wr_byte    <= '0;
      rd_next    <= 1'b0;
      bus_8bit   <= 1'b1;
      hi_q       <= '0;
      phase      <= NIB_HI;
    end else begin
      wr_valid   <= wv_n;
      wr_is_data <= tag_n;
      wr_byte    <= byte_n;
      rd_next    <= rn_n;
      bus_8bit   <= dl_n;
      hi_q       <= hi_n;
      phase      <= ph_n;
    end
  end
endmodule

// File: rtl/hb_rdpath.sv
module hb_rdpath
  import hb_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AC_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_next,
  input  logic [DW-1:0]   rd_data,
  input  logic            busy,
  input  logic [AC_W-1:0] ac,
  input  logic            rs,
  input  logic            bus_8bit,
  input  nib_ph_e         phase,
  output logic [DW-1:0]   rd_or,
  output logic [DW-1:0]   db_out
);
  localparam int NW   = DW / 2;
  localparam int PADW = DW - 1 - AC_W;

  logic [DW-1:0] or_n, status, sel;

  // Output register: hands out the prefetched byte, refills after each read.
  always_comb begin
    or_n = rd_or;
    if (rd_next) or_n = rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_or <= '0;
    else        rd_or <= or_n;
  end

  assign status = {busy, {PADW{1'b0}}, ac};
  assign sel    = rs ? rd_or : status;

  always_comb begin
    if (bus_8bit)             db_out = sel;
    else if (phase == NIB_HI) db_out = {sel[DW-1:NW], {NW{1'b0}}};
    else                      db_out = {sel[NW-1:0], {NW{1'b0}}};
  end
endmodule

// File: rtl/hostbus_front.sv
module hostbus_front
  import hb_pkg::*;
#(
  parameter int DW     = 8,
  parameter int AC_W   = 5,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_6800,
  input  logic            cs_n,
  input  logic            rs,
  input  logic            rw_wr,
  input  logic            e_rd,
  input  logic [DW-1:0]   db_in,
  output logic [DW-1:0]   db_out,
  output logic            db_oe,
  input  logic            busy,
  input  logic [AC_W-1:0] ac,
  input  logic [DW-1:0]   rd_data,
  output logic            wr_valid,
  output logic            wr_is_data,
  output logic [DW-1:0]   wr_byte,
  output logic            rd_next
);
  logic [1:0]    rst_q;
  logic          rst_core_n;
  logic          commit, c_rs, c_rd;
  logic [DW-1:0] c_d;
  logic          bus_8bit;
  nib_ph_e       phase;
  logic [DW-1:0] rd_or;

  // Reset asserts at once, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_core_n = rst_q[1];

  hb_strobe #(.DW(DW), .STAGES(STAGES)) u_strobe (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .mode_6800(mode_6800),
    .cs_n     (cs_n),
    .rs       (rs),
    .rw_wr    (rw_wr),
    .e_rd     (e_rd),
    .db_in    (db_in),
    .commit   (commit),
    .c_rs     (c_rs),
    .c_rd     (c_rd),
    .c_d      (c_d)
  );

  hb_width #(.DW(DW)) u_width (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .commit    (commit),
    .c_rs      (c_rs),
    .c_rd      (c_rd),
    .c_d       (c_d),
    .wr_valid  (wr_valid),
    .wr_is_data(wr_is_data),
    .wr_byte   (wr_byte),
    .rd_next   (rd_next),
    .bus_8bit  (bus_8bit),
    .phase     (phase)
  );

  hb_rdpath #(.DW(DW), .AC_W(AC_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .rd_next (rd_next),
    .rd_data (rd_data),
    .busy    (busy),
    .ac      (ac),
    .rs      (rs),
    .bus_8bit(bus_8bit),
    .phase   (phase),
    .rd_or   (rd_or),
    .db_out  (db_out)
  );

  // Drive only during an active, selected read strobe.
  assign db_oe = !cs_n && (mode_6800 ? (rw_wr && e_rd) : !e_rd);
endmodule

// File: rtl/hb_front_chk.sv
module hb_front_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          wr_valid,
  input logic          wr_is_data,
  input logic [DW-1:0] wr_byte,
  input logic          rd_next,
  input logic          bus_8bit,
  input logic [DW-1:0] rd_or
);
  logic [2:0] desel_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               desel_cnt <= 3'd0;
    else if (!cs_n)           desel_cnt <= 3'd0;
    else if (desel_cnt != 3'd7) desel_cnt <= desel_cnt + 3'd1;
  end

  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R11
  AST_RDNEXT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_next |=> !rd_next); // R11
  AST_SILENT_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (desel_cnt >= 3'd6) |-> (!wr_valid && !rd_next)); // R2
  AST_WIDTH_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_8bit) |-> (wr_valid && !wr_is_data && wr_byte[7:5] == 3'b001)); // R8
  AST_OUTREG_LOADS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_or) |-> $past(rd_next)); // R9
endmodule

bind hostbus_front hb_front_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .wr_valid  (wr_valid),
  .wr_is_data(wr_is_data),
  .wr_byte   (wr_byte),
  .rd_next   (rd_next),
  .bus_8bit  (bus_8bit),
  .rd_or     (rd_or)
);

// File: tb/hostbus_front_tb_top.sv
module hostbus_front_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_6800, cs_n, rs, rw_wr, e_rd;
  logic [7:0] db_in;
  logic [7:0] db_out;
  logic       db_oe;
  logic       busy;
  logic [4:0] bac;
  logic [7:0] rd_data;
  logic       wr_valid, wr_is_data, rd_next;
  logic [7:0] wr_byte;

  logic [7:0] mem [32];
  logic [8:0] exp_q [$];
  int         checks = 0;
  int         errors = 0;
  int         rdn_cnt = 0;
  int         wv_cnt = 0;
  int         exp_rdn = 0;
  logic       dl_b = 1'b1;
  logic       finished = 1'b0;

  always #5 clk = ~clk;

  hostbus_front dut_i (
    .clk(clk), .rst_n(rst_n), .mode_6800(mode_6800), .cs_n(cs_n), .rs(rs),
    .rw_wr(rw_wr), .e_rd(e_rd), .db_in(db_in), .db_out(db_out), .db_oe(db_oe),
    .busy(busy), .ac(bac), .rd_data(rd_data), .wr_valid(wr_valid),
    .wr_is_data(wr_is_data), .wr_byte(wr_byte), .rd_next(rd_next)
  );

  // Core model: RAM and address counter reacting to the block's outputs.
  assign rd_data = mem[bac];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) bac <= 5'd0;
    else begin
      if (wr_valid && wr_is_data) begin
        mem[bac] <= wr_byte;
        bac      <= bac + 5'd1;
      end else if (wr_valid && wr_byte[7]) begin
        bac <= wr_byte[4:0];
      end else if (rd_next) begin
        bac <= bac + 5'd1;
      end
    end
  end

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rd_next) rdn_cnt++;
    if (wr_valid) begin
      wv_cnt++;
      if (exp_q.size() == 0) begin
        chk("R11 unexpected write pulse", {wr_is_data, wr_byte}, 9'h1ff);
      end else begin
        chk("R1 R3 R5 write byte and tag", {wr_is_data, wr_byte}, exp_q.pop_front());
      end
    end
  end

  task automatic bus_xfer(input logic sel, input logic r_s, input logic rd,
                          input logic [7:0] d, output logic [7:0] q, output logic oe);
    @(negedge clk);
    rs = r_s; db_in = d;
    if (mode_6800) rw_wr = rd;
    repeat (2) @(negedge clk);
    cs_n = !sel;
    @(negedge clk);
    if (mode_6800)  e_rd = 1'b1;
    else if (rd)    e_rd = 1'b0;
    else            rw_wr = 1'b1;
    repeat (4) @(negedge clk);
    q = db_out; oe = db_oe;
    if (mode_6800)  e_rd = 1'b0;
    else if (rd)    e_rd = 1'b1;
    else            rw_wr = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wr_b(input logic r_s, input logic [7:0] b);
    logic [7:0] q; logic oe;
    exp_q.push_back({r_s, b});
    if (dl_b) begin
      bus_xfer(1'b1, r_s, 1'b0, b, q, oe);
    end else begin
      bus_xfer(1'b1, r_s, 1'b0, {b[7:4], 4'h5}, q, oe);
      bus_xfer(1'b1, r_s, 1'b0, {b[3:0], 4'ha}, q, oe);
    end
    chk("R12 no drive on write", {8'h0, oe}, 9'h0);
    if (!r_s && b[7:5] == 3'b001) dl_b = b[4];
  endtask

  task automatic rd_b(input logic r_s, input logic [7:0] exp, input string req);
    logic [7:0] q1, q2; logic oe1, oe2;
    if (dl_b) begin
      bus_xfer(1'b1, r_s, 1'b1, 8'h00, q1, oe1);
      chk(req, {1'b0, q1}, {1'b0, exp});
      chk("R12 drive on read", {8'h0, oe1}, 9'h1);
    end else begin
      bus_xfer(1'b1, r_s, 1'b1, 8'h00, q1, oe1);
      bus_xfer(1'b1, r_s, 1'b1, 8'h00, q2, oe2);
      chk({req, " R6 nibble order"}, {1'b0, q1[7:4], q2[7:4]}, {1'b0, exp});
      chk("R12 drive on nibble read", {7'h0, oe1, oe2}, 9'h3);
    end
    if (r_s) exp_rdn++;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] q; logic oe;
    int wv_before;
    mode_6800 = 1'b0; cs_n = 1'b1; rs = 1'b0; rw_wr = 1'b0; e_rd = 1'b1;
    db_in = 8'h00; busy = 1'b0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R7 R12: reset state
    chk("R7 R12 reset outputs", {db_oe, wr_valid, rd_next, 6'h0}, 9'h0);

    // R1 R3: separate-strobe writes, 8-bit
    wr_b(1'b0, 8'h80);
    wr_b(1'b1, 8'h41);
    wr_b(1'b1, 8'h42);
    wr_b(1'b1, 8'h43);

    // R10 R4: status read with busy
    busy = 1'b1;
    rd_b(1'b0, 8'h83, "R10 status busy+ac");
    busy = 1'b0;

    // R9: stale first read after address set (reset value 00)
    wr_b(1'b0, 8'h80);
    rd_b(1'b1, 8'h00, "R9 first read stale");
    rd_b(1'b1, 8'h41, "R9 prefetched read");
    rd_b(1'b1, 8'h42, "R9 prefetched read");
    chk("R11 read pulses", rdn_cnt[8:0], exp_rdn[8:0]);

    // R2 R12: deselected strobes
    wv_before = wv_cnt;
    bus_xfer(1'b0, 1'b1, 1'b0, 8'h99, q, oe);
    bus_xfer(1'b0, 1'b1, 1'b1, 8'h00, q, oe);
    chk("R12 no drive when deselected", {8'h0, oe}, 9'h0);
    chk("R2 no write when deselected", wv_cnt[8:0], wv_before[8:0]);
    chk("R2 no read when deselected", rdn_cnt[8:0], exp_rdn[8:0]);

    // R1 R4: switch to R/W plus enable scheme
    mode_6800 = 1'b1; e_rd = 1'b0; rw_wr = 1'b0;
    repeat (6) @(negedge clk);
    wr_b(1'b0, 8'h84);
    wr_b(1'b1, 8'h5a);
    wr_b(1'b1, 8'h5b);
    wr_b(1'b0, 8'h84);
    rd_b(1'b1, 8'h43, "R9 stale byte across address set");
    rd_b(1'b1, 8'h5a, "R4 R9 enable-strobe data read");
    rd_b(1'b0, 8'h06, "R4 R10 enable-strobe status");

    // R8 R5 R6: 4-bit width
    wr_b(1'b0, 8'h20);
    wr_b(1'b0, 8'h88);
    wr_b(1'b1, 8'hc3);
    wr_b(1'b0, 8'h88);
    rd_b(1'b1, 8'h5b, "R9 stale nibble pair");
    rd_b(1'b1, 8'hc3, "R6 nibble data read");
    busy = 1'b1;
    rd_b(1'b0, 8'h8a, "R10 nibble status");
    busy = 1'b0;
    chk("R11 read pulses after nibbles", rdn_cnt[8:0], exp_rdn[8:0]);

    // R8: back to 8-bit through a nibble command
    wr_b(1'b0, 8'h30);
    wr_b(1'b1, 8'h77);

    // R7: stray upper nibble, then reset, then nibble byte
    wr_b(1'b0, 8'h20);
    bus_xfer(1'b1, 1'b1, 1'b0, 8'hf0, q, oe);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; dl_b = 1'b1;
    repeat (5) @(negedge clk);
    wr_b(1'b0, 8'h20);
    wr_b(1'b1, 8'h9e);

    repeat (10) @(negedge clk);
    chk("R11 all expected writes seen", {1'b0, exp_q.size() == 0, 7'h0}, 9'h080);
    finished = 1'b1;
    finish_run();
  end
endmodule